// File: doc/BRIEF.md
# Overwriting Command Replay Buffer

This block keeps one multi-word command of up to thirteen 32-bit words so that a sequencer can send the same command again and again. Words arrive one per cycle on a push port. While the buffer has room, each push adds a word. Once it is full, each push drops the oldest word and keeps the new one. Writing thirteen fresh words therefore replaces a stale command completely, and no separate flush is needed.

A replay port walks the stored words from the oldest to the newest. The walk does not consume them. A start pulse rewinds the walk, each read pulse advances it by one word, and a done flag reports that every stored word has been read. The count of stored words is never changed by a replay, so the same command can be sent any number of times. A synchronous clear empties the buffer. Two sticky flags report misuse: a read while the buffer is empty, and an inconsistent state in which it reads as both full and empty.

Deciding when to replay belongs to the surrounding sequencer and is not part of this block.

Top module: `cmd_replay_buf`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, `full_o` is 0, `done_o` is 1, and both error flags are 0.
- R2: A push with `clr_i` low and the buffer not full stores `push_data_i` and raises `count_o` by one in the next cycle. `full_o` is 1 exactly when `count_o` equals DEPTH (13).
- R3: A push while full discards the oldest word and stores the new one. `count_o` stays at DEPTH. A later replay starts at the oldest surviving word.
- R4: After DEPTH pushes of new words, a replay returns only those words and nothing of the earlier command.
- R5: While `clr_i` is high, pushes are ignored. One cycle after `clr_i` is sampled high, `count_o` is 0, `empty_o` is 1 and the replay position is back at the start.
- R6: `rd_data_o` always shows the word at the current replay position. A `replay_start_i` pulse moves the position to the oldest word, visible in the next cycle, and it takes priority over `replay_rd_i` in the same cycle.
- R7: Each `replay_rd_i` pulse advances the position by one word and leaves `count_o` unchanged. Words come out in push order, and repeated replays return the same sequence.
- R8: `done_o` is 1 exactly when the replay position equals `count_o`. A `replay_rd_i` while `done_o` is 1 leaves the position unchanged.
- R9: A `replay_rd_i` while `empty_o` is 1 sets `err_rd_empty_o` in the next cycle. The flag stays set until reset and is not cleared by `clr_i`.
- R10: `err_state_o` is set if full and empty are ever seen together and then stays set until reset. In consistent operation it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear; blocks pushes while high |
| push_i | input | 1 | Push request for one word |
| push_data_i | input | WIDTH | Word to push |
| replay_start_i | input | 1 | Rewind replay position to the oldest word |
| replay_rd_i | input | 1 | Advance replay position by one word |
| rd_data_o | output | WIDTH | Word at the current replay position |
| count_o | output | CNT_W | Number of stored words |
| full_o | output | 1 | Buffer holds DEPTH words |
| empty_o | output | 1 | Buffer holds no words |
| done_o | output | 1 | Replay position has reached the stored count |
| err_rd_empty_o | output | 1 | Sticky: replay read while empty |
| err_state_o | output | 1 | Sticky: full and empty seen together |

## Verification
The bench builds the block with its default parameters: DEPTH of 13 and WIDTH of 32. Because 13 is not a power of two, the position wrap and the head-plus-offset replay index both cross the non-binary boundary. Eviction is reached after thirteen pushes and full replacement after another thirteen, so both fit in a few hundred cycles. Replays run both on a partly filled buffer and on a buffer whose oldest word sits mid-array after evictions.

// File: rtl/cmdrep_pkg.sv
package cmdrep_pkg;

  // Modular add of two indices already below depth.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Next index with wrap at depth.
  function automatic int unsigned wrap_inc(input int unsigned idx,
                                           input int unsigned depth);
    return wrap_add(idx, 1, depth);
  endfunction

  typedef struct packed {
    logic rd_empty;
    logic state;
  } err_flags_t;

endpackage

// File: rtl/cmdrep_store.sv
module cmdrep_store #(
  parameter int unsigned DEPTH = 13,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = mem_q[i];
    end
  end

endmodule

// File: rtl/cmdrep_occupancy.sv
module cmdrep_occupancy #(
  parameter int unsigned DEPTH = 13,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  output logic             accept_o,
  output logic             evict_o,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  import cmdrep_pkg::*;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [IDX_W-1:0] head_nx, tail_nx;

  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign accept_o = push_i && !clr_i;
  assign evict_o  = accept_o && full_o;

  assign head_nx = IDX_W'(wrap_inc(int'(head_q), DEPTH));
  assign tail_nx = IDX_W'(wrap_inc(int'(tail_q), DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clr_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (accept_o) begin
      tail_q <= tail_nx;
      if (full_o) head_q  <= head_nx;
      else        count_q <= count_q + CNT_W'(1);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

endmodule

// File: rtl/cmdrep_replay.sv
module cmdrep_replay #(
  parameter int unsigned DEPTH = 13,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] off_o,
  output logic             adv_o,
  output logic             done_o
);

  logic [CNT_W-1:0] off_q;

  assign done_o = (off_q == count_i);
  assign adv_o  = rd_i && !start_i && !clr_i && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                off_q <= '0;
    else if (clr_i || start_i)  off_q <= '0;
    else if (adv_o)             off_q <= off_q + CNT_W'(1);
  end

  assign off_o = off_q;

endmodule

// File: rtl/cmdrep_err.sv
module cmdrep_err (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  logic                   full_i,
  input  logic                   empty_i,
  output logic                   rd_empty_ev_o,
  output logic                   state_ev_o,
  output cmdrep_pkg::err_flags_t flags_o
);
  import cmdrep_pkg::*;

  err_flags_t flags_q;

  assign rd_empty_ev_o = rd_i && empty_i;
  assign state_ev_o    = full_i && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      if (rd_empty_ev_o) flags_q.rd_empty <= 1'b1;
      if (state_ev_o)    flags_q.state    <= 1'b1;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/cmd_replay_buf.sv
module cmd_replay_buf #(
  parameter int unsigned DEPTH = 13,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             replay_start_i,
  input  logic             replay_rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             done_o,
  output logic             err_rd_empty_o,
  output logic             err_state_o
);
  import cmdrep_pkg::*;

  // Named internal events, visible to the bound checker.
  logic             push_ok;
  logic             evict_ev;
  logic             adv_ev;
  logic             rd_empty_ev;
  logic             state_ev;
  logic [IDX_W-1:0] head;
  logic [IDX_W-1:0] tail;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] off;
  logic [IDX_W-1:0] rd_idx;
  logic             full;
  logic             empty;
  logic             done;
  err_flags_t       flags;

  cmdrep_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .push_i   (push_i),
    .accept_o (push_ok),
    .evict_o  (evict_ev),
    .head_o   (head),
    .tail_o   (tail),
    .count_o  (count),
    .full_o   (full),
    .empty_o  (empty)
  );

  cmdrep_replay #(.DEPTH(DEPTH)) u_rep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .start_i (replay_start_i),
    .rd_i    (replay_rd_i),
    .count_i (count),
    .off_o   (off),
    .adv_o   (adv_ev),
    .done_o  (done)
  );

  // Replay index: oldest word plus offset, wrapped at DEPTH.
  assign rd_idx = IDX_W'(wrap_add(int'(head), int'(off), DEPTH));

  cmdrep_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_ok),
    .wr_idx_i  (tail),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data_o)
  );

  cmdrep_err u_err (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_i          (replay_rd_i),
    .full_i        (full),
    .empty_i       (empty),
    .rd_empty_ev_o (rd_empty_ev),
    .state_ev_o    (state_ev),
    .flags_o       (flags)
  );

  assign count_o        = count;
  assign full_o         = full;
  assign empty_o        = empty;
  assign done_o         = done;
  assign err_rd_empty_o = flags.rd_empty;
  assign err_state_o    = flags.state;

endmodule

// File: rtl/cmdrep_checker.sv
module cmdrep_checker #(
  parameter int unsigned DEPTH = 13,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             push_i,
  input logic             start_i,
  input logic             rd_i,
  input logic             push_ok,
  input logic             evict_ev,
  input logic             adv_ev,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] off,
  input logic             full,
  input logic             empty,
  input logic             done,
  input logic             err_rd,
  input logic             err_state
);

  p_push_grow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok && !full |=> count == $past(count) + CNT_W'(1));

  p_evict_keeps_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_ev |=> full && count == $past(count));

  p_clear_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty && off == '0);

  p_rewind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !clr_i |=> off == '0);

  p_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_ev |=> off == $past(off) + CNT_W'(1));

  p_count_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !push_i && !clr_i |=> count == $past(count));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && rd_i && !start_i && !clr_i && !push_i |=> done && $stable(off));

  p_rd_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && empty |=> err_rd);

  p_rd_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_rd |=> err_rd);

  p_consistent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full && empty));

  p_state_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_state |=> err_state);

endmodule

bind cmd_replay_buf cmdrep_checker #(.DEPTH(DEPTH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .push_i    (push_i),
  .start_i   (replay_start_i),
  .rd_i      (replay_rd_i),
  .push_ok   (push_ok),
  .evict_ev  (evict_ev),
  .adv_ev    (adv_ev),
  .count     (count),
  .off       (off),
  .full      (full),
  .empty     (empty),
  .done      (done),
  .err_rd    (err_rd_empty_o),
  .err_state (err_state_o)
);

// File: tb/test_cmd_replay_buf.sv
`timescale 1ns/1ps
module test_cmd_replay_buf;
  localparam int unsigned DEPTH = 13;
  localparam int unsigned WIDTH = 32;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr = 1'b0;
  logic             push = 1'b0;
  logic [WIDTH-1:0] push_data = '0;
  logic             start = 1'b0;
  logic             rd = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic [CNT_W-1:0] count;
  logic             full, empty, done, err_rd, err_state;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [WIDTH-1:0] model[$];
  logic [WIDTH-1:0] exp_q[$];

  always #5 clk = ~clk;

  cmd_replay_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_cmd_replay_buf (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .clr_i          (clr),
    .push_i         (push),
    .push_data_i    (push_data),
    .replay_start_i (start),
    .replay_rd_i    (rd),
    .rd_data_o      (rd_data),
    .count_o        (count),
    .full_o         (full),
    .empty_o        (empty),
    .done_o         (done),
    .err_rd_empty_o (err_rd),
    .err_state_o    (err_state)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push_word(input logic [WIDTH-1:0] d);
    push = 1'b1;
    push_data = d;
    step();
    push = 1'b0;
    if (model.size() == DEPTH) void'(model.pop_front());
    model.push_back(d);
  endtask

  // Driver: load the scoreboard with the expected sequence, then walk it.
  task automatic replay_all(input string tag);
    foreach (model[i]) exp_q.push_back(model[i]);
    start = 1'b1;
    step();
    start = 1'b0;
    repeat (model.size()) begin
      rd = 1'b1;
      step();
    end
    rd = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " scoreboard drained"}, exp_q.size(), 0);
    check(done == 1'b1, {tag, " R8 done after full walk"}, done, 1);
    check(count == CNT_W'(model.size()), {tag, " R7 count kept"}, count, model.size());
  endtask

  // Monitor: compare each word read against the scoreboard.
  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      automatic logic [WIDTH-1:0] e = exp_q.pop_front();
      check(rd_data == e, "R7 replay word order", rd_data, e);
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(count == 0, "R1 count", count, 0);
    check(empty && !full, "R1 empty/full", {empty, full}, 2'b10);
    check(done == 1'b1, "R1 done", done, 1);
    check(!err_rd && !err_state, "R1 errors", {err_rd, err_state}, 0);

    // R2: partial fill
    step();
    push_word(32'hA000_0001);
    push_word(32'hA000_0002);
    push_word(32'hA000_0003);
    @(negedge clk);
    check(count == 3, "R2 count after 3 pushes", count, 3);
    check(!empty && !full, "R2 flags partial", {empty, full}, 0);
    check(done == 1'b0, "R8 not done when position below count", done, 0);
    check(rd_data == 32'hA000_0001, "R6 data at oldest", rd_data, 32'hA000_0001);
    step();
    replay_all("R7 partial");

    // R8: read while done keeps position
    rd = 1'b1;
    step();
    rd = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R8 read while done", done, 1);
    check(err_rd == 1'b0, "R9 no error when not empty", err_rd, 0);

    // R6: start wins over read in the same cycle
    step();
    start = 1'b1;
    rd = 1'b1;
    step();
    start = 1'b0;
    rd = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R6 rewind done low", done, 0);
    check(rd_data == 32'hA000_0001, "R6 rewind to oldest", rd_data, 32'hA000_0001);

    // R2: fill to DEPTH
    step();
    for (int i = 4; i <= DEPTH; i++) push_word(32'hA000_0000 + i);
    @(negedge clk);
    check(count == DEPTH, "R2 count full", count, DEPTH);
    check(full && !empty, "R2 full flag", {full, empty}, 2'b10);

    // R3: evict two oldest
    step();
    push_word(32'hB000_0001);
    push_word(32'hB000_0002);
    @(negedge clk);
    check(count == DEPTH, "R3 count stays full", count, DEPTH);
    step();
    replay_all("R3 after evict");
    check(model[0] == 32'hA000_0003, "R3 oldest survivor", model[0], 32'hA000_0003);

    // R4: full replacement
    step();
    for (int i = 0; i < DEPTH; i++) push_word(32'hC000_0100 + i);
    step();
    replay_all("R4 replaced");
    step();
    replay_all("R7 second replay");

    // R5: clear with push held
    step();
    clr = 1'b1;
    push = 1'b1;
    push_data = 32'hDEAD_BEEF;
    step();
    step();
    clr = 1'b0;
    push = 1'b0;
    model.delete();
    @(negedge clk);
    check(count == 0 && empty, "R5 cleared, push ignored", count, 0);
    check(done == 1'b1, "R5 position reset", done, 1);
    step();
    push_word(32'hE000_0001);
    @(negedge clk);
    check(count == 1, "R5 push after clear", count, 1);
    check(rd_data == 32'hE000_0001, "R5 first word after clear", rd_data, 32'hE000_0001);

    // R9: read while empty
    step();
    clr = 1'b1;
    step();
    clr = 1'b0;
    model.delete();
    @(negedge clk);
    check(err_rd == 1'b0, "R9 flag low before", err_rd, 0);
    step();
    rd = 1'b1;
    step();
    rd = 1'b0;
    @(negedge clk);
    check(err_rd == 1'b1, "R9 flag set", err_rd, 1);
    step();
    clr = 1'b1;
    step();
    clr = 1'b0;
    push_word(32'hF000_0001);
    @(negedge clk);
    check(err_rd == 1'b1, "R9 flag sticky across clear", err_rd, 1);

    // R10
    check(err_state == 1'b0, "R10 state flag low", err_state, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule